// File: doc/BRIEF.md
# Variable-Length Serial Frame Master

This block is a serial-peripheral master that sits on a 16-bit register bus. Software loads a 32-bit outgoing word as two 16-bit halves. It then writes a command word that gives the frame length (1 to 32 bits), a 3-bit target address and the frame kind: transmit-only or full-duplex. The block drives one of five active-low selects, toggles the serial clock in mode 0 (idle low), sends the word most-significant bit first and collects the incoming bits into a right-justified receive word.

When the frame ends, the block sets an end flag for every frame and a second flag for full-duplex frames only. Software either polls these flags or uses the interrupt line. Each flag reaches the interrupt line only while its mask bit is clear. A programmable divider sets the serial clock rate, and a clock-enable bit can freeze a frame partway through.

Top module: `spi_frame_master`

## Requirements
- R1: After reset every select output is high, the serial clock is low, the interrupt is low, and the configuration, divider and flag registers read 0.
- R2: The word offset is taken from bus byte offset bits 3:1. The registers and their writable bits are:
  - 0x0: config, bit 0 clock enable, bit 4 write-end mask, bit 5 read-end mask.
  - 0x2: divider, bits 3:0.
  - 0x4: command.
  - 0x6: flags.
  - 0x8 and 0xA: transmit low and high halves.
  - 0xC and 0xE: receive low and high halves.
  
  Every writable bit reads back; every other bit reads 0.
- R3: A command write with bit 0 set starts a full-duplex frame. A command write with only bit 1 set starts a transmit-only frame. A command write with neither bit set starts nothing and leaves the flags unchanged.
- R4: Command bits 6:2 hold the frame length minus one, and a frame produces exactly that many plus one rising serial clock edges.
- R5: Each serial clock half-period lasts divider+1 bus clock cycles. The select goes low one half-period before the first rising edge and goes high one half-period after the last falling edge.
- R6: The serial output starts with bit 31 of {transmit high, transmit low} and walks downward. It changes only while the serial clock is low.
- R7: A full-duplex frame samples the serial input on each rising edge and shifts it into the receive word, so the last bit lands in bit 0 and unused upper bits are 0. A transmit-only frame leaves the receive word unchanged.
- R8: Command bits 9:7 pick select output N for N from 0 to 4. Addresses 5 to 7 drive no select, but the frame still runs to completion.
- R9: Flag bit 1 (write end) sets at the end of every frame. Flag bit 0 (read end) sets only at the end of a full-duplex frame. Both flags clear when a frame starts.
- R10: The interrupt is high when write end is set and unmasked, or when read end is set and unmasked.
- R11: A start command written while a frame is running is ignored, and the running frame keeps its length, address and data.
- R12: While clock enable is 0, a running frame holds its state: the serial clock does not move and the select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 5 | Active-low device selects |
| irq | output | 1 | Frame-end interrupt |

## Verification
The assertions assume that the bus performs a write only on a cycle where bus_sel and bus_we are both high. They also assume that reset is applied before the first access, so the flags and the select register start from known values. The stimulus holds each access for exactly one clock edge and changes bus and serial-input values only on falling clock edges. It drives the serial input from a slave word that is stepped once per bit, so the value stays stable across every sampling edge. Mid-frame traffic is limited to one deliberate conflicting start command and one clock-enable change.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2,
    PH_TRAIL = 2'd3
  } phase_e;

  // word index (byte offset >> 1) of each register
  localparam logic [2:0] IDX_CFG   = 3'd0;
  localparam logic [2:0] IDX_DIV   = 3'd1;
  localparam logic [2:0] IDX_CMD   = 3'd2;
  localparam logic [2:0] IDX_FLAGS = 3'd3;
  localparam logic [2:0] IDX_TXLO  = 3'd4;
  localparam logic [2:0] IDX_TXHI  = 3'd5;
  localparam logic [2:0] IDX_RXLO  = 3'd6;
  localparam logic [2:0] IDX_RXHI  = 3'd7;

  // half-period length in bus cycles for a divider setting
  function automatic int unsigned half_cycles(input int unsigned div);
    return div + 1;
  endfunction

  // cycles from start-command edge until the frame is back to idle
  function automatic int unsigned frame_cycles(input int unsigned nbits,
                                               input int unsigned div);
    return (2 * nbits + 1) * half_cycles(div);
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             half_tick
);

  logic [DIV_W-1:0] cnt_q;

  assign half_tick = busy && en && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!busy) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= (cnt_q == div) ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_frame_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              duplex_in,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              half_tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic              duplex,
  output logic [DATA_W-1:0] rx_word
);

  phase_e            phase_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [LEN_W-1:0]  left_q;
  logic              dup_q;

  assign busy    = (phase_q != PH_IDLE);
  assign sclk    = (phase_q == PH_HIGH);
  assign mosi    = tx_sh_q[DATA_W-1];
  assign done    = half_tick && (phase_q == PH_TRAIL);
  assign duplex  = dup_q;
  assign rx_word = rx_sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      left_q  <= '0;
      dup_q   <= 1'b0;
    end else if (start) begin
      phase_q <= PH_SETUP;
      tx_sh_q <= tx_word;
      rx_sh_q <= '0;
      left_q  <= len_m1;
      dup_q   <= duplex_in;
    end else if (half_tick) begin
      unique case (phase_q)
        PH_SETUP: begin
          phase_q <= PH_HIGH;
          rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
        end
        PH_HIGH: begin
          if (left_q == '0) begin
            phase_q <= PH_TRAIL;
          end else begin
            phase_q <= PH_SETUP;
            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
            left_q  <= left_q - 1'b1;
          end
        end
        PH_TRAIL: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
  parameter int NUM_CS = 5,
  parameter int ADDR_W = 3
) (
  input  logic              active,
  input  logic [ADDR_W-1:0] dev,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
    assign cs_n[i] = !(active && (dev == ADDR_W'(i)));
  end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_frame_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5,
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 4,
  parameter int NUM_CS = 5,
  parameter int BUS_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);

  // command field positions
  localparam int LEN_LO = 2;
  localparam int LEN_HI = LEN_LO + LEN_W - 1;
  localparam int DEV_LO = LEN_HI + 1;
  localparam int DEV_HI = DEV_LO + ADDR_W - 1;
  localparam int CMD_RB = DEV_HI + 1;
  // config bit positions
  localparam int CFG_EN    = 0;
  localparam int CFG_MWE   = 4;
  localparam int CFG_MRE   = 5;

  logic [2:0] widx;
  assign widx = bus_addr[BUS_AW-1:1];

  logic wr_strobe;
  assign wr_strobe = bus_sel && bus_we;

  logic unused_addr_lsb;
  assign unused_addr_lsb = bus_addr[0];

  // register state
  logic              clk_en, mask_we, mask_re;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] dev_q;
  logic              flag_we, flag_re;

  // internal events
  logic busy, half_tick, frame_start, frame_done, cmd_write, cur_duplex;
  logic [DATA_W-1:0] rx_word;

  assign cmd_write   = wr_strobe && (widx == IDX_CMD);
  assign frame_start = cmd_write && (bus_wdata[0] || bus_wdata[1]) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en  <= 1'b0;
      mask_we <= 1'b0;
      mask_re <= 1'b0;
      div_q   <= '0;
      tx_q    <= '0;
    end else if (wr_strobe) begin
      unique case (widx)
        IDX_CFG: begin
          clk_en  <= bus_wdata[CFG_EN];
          mask_we <= bus_wdata[CFG_MWE];
          mask_re <= bus_wdata[CFG_MRE];
        end
        IDX_DIV:  div_q <= bus_wdata[DIV_W-1:0];
        IDX_TXLO: tx_q[REG_W-1:0] <= bus_wdata;
        IDX_TXHI: tx_q[DATA_W-1:REG_W] <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      dev_q   <= '0;
      flag_we <= 1'b0;
      flag_re <= 1'b0;
      rx_q    <= '0;
    end else if (frame_start) begin
      len_q   <= bus_wdata[LEN_HI:LEN_LO];
      dev_q   <= bus_wdata[DEV_HI:DEV_LO];
      flag_we <= 1'b0;
      flag_re <= 1'b0;
    end else if (frame_done) begin
      flag_we <= 1'b1;
      flag_re <= cur_duplex;
      if (cur_duplex) rx_q <= rx_word;
    end
  end

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .en        (clk_en),
    .div       (div_q),
    .half_tick (half_tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_start),
    .duplex_in (bus_wdata[0]),
    .len_m1    (bus_wdata[LEN_HI:LEN_LO]),
    .tx_word   (tx_q),
    .half_tick (half_tick),
    .miso      (miso),
    .busy      (busy),
    .sclk      (sclk),
    .mosi      (mosi),
    .done      (frame_done),
    .duplex    (cur_duplex),
    .rx_word   (rx_word)
  );

  spi_cs_decode #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_cs (
    .active (busy),
    .dev    (dev_q),
    .cs_n   (cs_n)
  );

  assign irq = (flag_we && !mask_we) || (flag_re && !mask_re);

  always_comb begin
    bus_rdata = '0;
    unique case (widx)
      IDX_CFG: begin
        bus_rdata[CFG_EN]  = clk_en;
        bus_rdata[CFG_MWE] = mask_we;
        bus_rdata[CFG_MRE] = mask_re;
      end
      IDX_DIV:   bus_rdata[DIV_W-1:0] = div_q;
      IDX_CMD:   bus_rdata[CMD_RB-1:LEN_LO] = {dev_q, len_q};
      IDX_FLAGS: bus_rdata[1:0] = {flag_we, flag_re};
      IDX_TXLO:  bus_rdata = tx_q[REG_W-1:0];
      IDX_TXHI:  bus_rdata = tx_q[DATA_W-1:REG_W];
      IDX_RXLO:  bus_rdata = rx_q[REG_W-1:0];
      IDX_RXHI:  bus_rdata = rx_q[DATA_W-1:REG_W];
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_frame_checker.sv
module spi_frame_checker #(
  parameter int NUM_CS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n,
  input logic              irq,
  input logic              busy,
  input logic              clk_en,
  input logic              frame_start,
  input logic              frame_done,
  input logic              flag_we,
  input logic              flag_re
);

  // R8: at most one device select low at any time
  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R5: serial clock stays low outside a frame
  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R6: serial output never moves while the serial clock is high
  a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  // R9: an accepted start leaves both flags clear
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!flag_we && !flag_re));

  // R9: frame end raises write-end
  a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> flag_we);

  // R10: no interrupt without a pending flag
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we && !flag_re) |-> !irq);

  // R12: a frozen clock enable keeps the serial clock still
  a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clk_en) |=> $stable(sclk));

endmodule

bind spi_frame_master spi_frame_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk        (sclk),
  .mosi        (mosi),
  .cs_n        (cs_n),
  .irq         (irq),
  .busy        (busy),
  .clk_en      (clk_en),
  .frame_start (frame_start),
  .frame_done  (frame_done),
  .flag_we     (flag_we),
  .flag_re     (flag_re)
);

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        sclk, mosi, irq;
  logic        miso = 1'b0;
  logic [4:0]  cs_n;

  int checks = 0;
  int fails = 0;
  bit reported = 0;
  logic [31:0] rx_shadow = 32'h0;
  logic [15:0] cfg_shadow = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  // call at a falling edge; no clock edge consumed
  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 0;
  endtask

  // cycle-by-cycle reference: after k edges past the start edge,
  // half-period index p = k / h; p < 2n toggles, p == 2n trailing, then idle
  task automatic run_frame(input int n, input int a, input int kind,
                           input logic [31:0] tx, input logic [31:0] sv,
                           input int h, input bit poke);
    logic [15:0] rd;
    logic [15:0] cmdw;
    logic [4:0]  exp_cs;
    bit dup;
    bit exp_irq_end;
    int total;
    dup = (kind & 1) != 0;
    exp_irq_end = (!cfg_shadow[4]) || (dup && !cfg_shadow[5]);
    bus_write(4'hA, tx[31:16]);
    bus_write(4'h8, tx[15:0]);
    cmdw = 16'(kind & 3) | 16'((n - 1) << 2) | 16'(a << 7);
    total = (2 * n + 1) * h;
    bus_write(4'h4, cmdw);
    for (int k = 0; k <= total; k++) begin
      int p;
      p = k / h;
      miso = (p < 2 * n) ? sv[31 - p / 2] : 1'b0;
      if (poke && k == 2) begin
        bus_sel = 1; bus_we = 1; bus_addr = 4'h4;
        bus_wdata = 16'h0001 | 16'(2 << 2) | 16'(0 << 7);
      end
      if (poke && k == 3) begin
        bus_sel = 0; bus_we = 0;
      end
      #1;
      exp_cs = (p <= 2 * n && a < 5) ? ~(5'b00001 << a) : 5'b11111;
      check(poke ? "R11 select during ignored restart" : "R8/R5 select window", 32'(cs_n), 32'(exp_cs));
      check("R4/R5 serial clock", 32'(sclk), 32'((p < 2 * n) && (p % 2 == 1)));
      if (p < 2 * n) check("R6 serial out bit", 32'(mosi), 32'(tx[31 - p / 2]));
      check("R10 interrupt", 32'(irq), 32'((p > 2 * n) ? exp_irq_end : 1'b0));
      if (k < total) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    bus_read(4'h6, rd);
    check("R9 flags after frame", 32'(rd), 32'({dup, 1'b1}) == 0 ? 0 : 32'(2 | int'(dup)));
    if (dup) rx_shadow = (n == 32) ? sv : (sv >> (32 - n));
    bus_read(4'hC, rd);
    check(dup ? "R7 receive low" : "R7 receive low unchanged", 32'(rd), 32'(rx_shadow[15:0]));
    bus_read(4'hE, rd);
    check(dup ? "R7 receive high" : "R7 receive high unchanged", 32'(rd), 32'(rx_shadow[31:16]));
    bus_read(4'h4, rd);
    check("R11 command fields kept", 32'(rd), 32'(cmdw & 16'h03FC));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    check("R1 selects idle", 32'(cs_n), 32'h1F);
    check("R1 sclk low", 32'(sclk), 0);
    check("R1 irq low", 32'(irq), 0);
    bus_read(4'h6, rd); check("R1 flags zero", 32'(rd), 0);
    bus_read(4'h0, rd); check("R1 config zero", 32'(rd), 0);
    bus_read(4'h2, rd); check("R1 divider zero", 32'(rd), 0);
    @(negedge clk); rst_n = 1;

    // R2 register map
    bus_write(4'h0, 16'hFFFF);
    bus_read(4'h0, rd); check("R2 config readback", 32'(rd), 32'h0031);
    bus_write(4'h2, 16'hFFF3);
    bus_read(4'h2, rd); check("R2 divider readback", 32'(rd), 32'h0003);
    bus_write(4'hA, 16'hBEEF);
    bus_write(4'h8, 16'h1357);
    bus_read(4'hA, rd); check("R2 tx high readback", 32'(rd), 32'hBEEF);
    bus_read(4'h8, rd); check("R2 tx low readback", 32'(rd), 32'h1357);

    // R3/R4/R7 duplex byte, fastest clock
    cfg_shadow = 16'h0001; bus_write(4'h0, cfg_shadow);
    bus_write(4'h2, 16'h0000);
    run_frame(8, 0, 1, 32'hA500_0000, 32'h96F0_1234, 1, 0);

    // full word, slow clock, read-end masked
    cfg_shadow = 16'h0021; bus_write(4'h0, cfg_shadow);
    bus_write(4'h2, 16'h0002);
    run_frame(32, 4, 1, 32'h1234_5678, 32'hDEAD_BEEF, 3, 0);

    // R3 one-bit transmit-only, RX unchanged, both masks
    cfg_shadow = 16'h0031; bus_write(4'h0, cfg_shadow);
    bus_write(4'h2, 16'h0001);
    run_frame(1, 2, 2, 32'h8000_0000, 32'hFFFF_FFFF, 2, 0);

    // R8 address with no select
    cfg_shadow = 16'h0011; bus_write(4'h0, cfg_shadow);
    run_frame(13, 6, 2, 32'hC3A5_0000, 32'h0000_0000, 2, 0);

    // R3 both start bits set acts as duplex
    run_frame(17, 3, 3, 32'h0F0F_8001, 32'hA5A5_5A5A, 2, 0);

    // R11 start written mid-frame is ignored
    cfg_shadow = 16'h0001; bus_write(4'h0, cfg_shadow);
    run_frame(8, 1, 1, 32'h5A00_0000, 32'h6600_0000, 2, 1);

    // R12 clock enable cleared freezes the frame
    cfg_shadow = 16'h0000; bus_write(4'h0, cfg_shadow);
    bus_write(4'h4, 16'h0002 | 16'(3 << 2) | 16'(1 << 7));
    for (int i = 0; i < 12; i++) begin
      #1;
      if (sclk !== 1'b0 || cs_n !== 5'b11101) begin
        checks++; fails++;
        $display("FAIL R12 frozen frame actual=%b/%b expected=0/11101", sclk, cs_n);
      end
      @(negedge clk);
    end
    check("R12 frozen frame held", 32'({sclk, cs_n}), 32'({1'b0, 5'b11101}));
    bus_read(4'h6, rd); check("R9 flags cleared by start", 32'(rd), 0);
    cfg_shadow = 16'h0001; bus_write(4'h0, cfg_shadow);
    for (int i = 0; i < 200 && cs_n !== 5'h1F; i++) @(negedge clk);
    bus_read(4'h6, rd); check("R12 frame finishes after enable", 32'(rd), 32'h2);

    // R3 command with neither start bit does nothing
    bus_write(4'h4, 16'(7 << 2) | 16'(0 << 7));
    repeat (4) @(negedge clk);
    #1;
    check("R3 no start select", 32'(cs_n), 32'h1F);
    check("R3 no start sclk", 32'(sclk), 0);
    bus_read(4'h6, rd); check("R3 flags untouched", 32'(rd), 32'h2);

    report();
  end

endmodule